// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the slave side of a serial memory reached over a four-wire SPI link. It holds 512 bytes in on-chip registers and answers one-byte commands for setting and clearing a write-enable latch, reading and writing a small status byte, streaming data out of the array, and loading a page of data into the array. Chip select, serial clock, serial data in and an active-low hold pin are brought into the system clock domain through synchronizers. Edges of the serial clock are detected there. Both SPI modes 0 and 3 work, because only edges are used.

The serial engine shifts opcodes and addresses in on rising serial-clock edges and drives MISO after falling edges. MISO has a separate output enable so that the pad can be tri-stated. Completed write and status-write commands go to a storage unit as requests. That unit holds the write-enable latch, the two protection bits and the busy timer. It accepts or rejects each request. The self-timed write time is a parameter counted in system clocks.

A host pauses a transfer with the hold pin without ending it. A host abandons a transfer by raising chip select while the transfer is held.

Top module: `spi_eeprom_slave`

## Requirements
- R1: After reset every array byte reads 0xFF, the status byte reads 0x00 and MISO is not driven.
- R2: Status byte layout: bit 0 busy, bit 1 write-enable latch, bits 3:2 protection code, bits 7:4 zero. Opcode 0x06 sets the latch and 0x04 clears it. Opcode 0x05 returns the live status byte again on every byte while CS stays low.
- R3: Array opcodes are 0000_h011 (read) and 0000_h010 (write). Bit 3 (h) is address bit 8, and one byte of address bits 7:0 follows the opcode.
- R4: Write data fills a PAGE-byte page. Only the in-page offset advances, so bytes past the page end wrap to its start and overwrite bytes loaded earlier in the same command.
- R5: Read data advances through the whole array and wraps from 0x1FF to 0x000 while CS stays low.
- R6: A write (or status write) commits only if CS rises right after a full byte with at least one data byte received. A rise in mid-byte discards it, and the next CS low starts a fresh opcode.
- R7: A write or status write is rejected if the write-enable latch is clear.
- R8: While busy, a read opcode is rejected and MISO stays undriven for the rest of that selection. The status read still works and shows busy.
- R9: A committed write sets busy for WR_CYCLES clocks. When busy ends, the write-enable latch is cleared.
- R10: Status write (opcode 0x01, then one byte) loads the protection code from data bits 3:2 at the end of its busy time. Code 01 protects the top quarter, 10 the top half and 11 the whole array. A write to a protected page is rejected without starting busy.
- R11: An opcode whose bits 7:4 are not zero, or whose low bits are unused, makes the rest of the selection ignored.
- R12: Hold starts when the hold pin falls while SCK is low and CS is low. It ends when the pin rises while SCK is low. While held, MISO is undriven and SCK/MOSI have no effect.
- R13: Raising CS during hold abandons the transfer: no write commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, faster than SCK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sck_i | input | 1 | Serial clock |
| mosi_i | input | 1 | Serial data in |
| hold_ni | input | 1 | Hold, active low |
| miso_o | output | 1 | Serial data out |
| miso_oe_o | output | 1 | Output enable for MISO |

## Verification
The bench drives a page write that starts mid-page and runs past the page end. A design that advanced the whole address would spill into the next page instead of overwriting the earlier bytes. It reads across the top of the array to catch a counter that saturates or wraps only within a page. It ends writes with stray bits, under hold, with protected pages and with the latch clear, and in each case confirms through status and read-back that nothing committed. It issues a read while busy and pauses a read in hold. A design that ignored busy, or that counted clock pulses sent during hold, would drive MISO or shift the wrong byte.

// File: rtl/spi_ee_pkg.sv
package spi_ee_pkg;
  typedef enum logic [2:0] {
    ST_OP, ST_ADDR, ST_RD, ST_SRO, ST_SRI, ST_SRD, ST_WR, ST_IGN
  } ee_state_e;

  localparam logic [2:0] OPL_WREN = 3'b110;
  localparam logic [2:0] OPL_WRDI = 3'b100;
  localparam logic [2:0] OPL_RDSR = 3'b101;
  localparam logic [2:0] OPL_WRSR = 3'b001;
  localparam logic [2:0] OPL_READ = 3'b011;
  localparam logic [2:0] OPL_WRIT = 3'b010;
endpackage

// File: rtl/spi_ee_frontend.sv
module spi_ee_frontend #(
  parameter int SYNC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_ni,
  output logic sel_o,
  output logic cs_rise_o,
  output logic hold_o,
  output logic bit_rise_o,
  output logic bit_fall_o,
  output logic mosi_o
);
  localparam logic [3:0] RST_V = 4'b1001;  // hold, mosi, sck, cs

  logic [SYNC-1:0][3:0] ff_q;
  logic [3:0] s;
  logic cs_p, sck_p, hold_p, hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SYNC; i++) ff_q[i] <= RST_V;
    end else begin
      ff_q[0] <= {hold_ni, mosi_i, sck_i, cs_ni};
      for (int i = 1; i < SYNC; i++) ff_q[i] <= ff_q[i-1];
    end
  end

  assign s = ff_q[SYNC-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_p   <= 1'b1;
      sck_p  <= 1'b0;
      hold_p <= 1'b1;
      hold_q <= 1'b0;
    end else begin
      cs_p   <= s[0];
      sck_p  <= s[1];
      hold_p <= s[3];
      if (s[0]) hold_q <= 1'b0;
      else if (!hold_q && !s[3] && hold_p && !s[1]) hold_q <= 1'b1;
      else if (hold_q && s[3] && !hold_p && !s[1]) hold_q <= 1'b0;
    end
  end

  assign sel_o      = !s[0];
  assign cs_rise_o  = s[0] && !cs_p;
  assign hold_o     = hold_q;
  assign bit_rise_o = !s[0] && !hold_q && s[1] && !sck_p;
  assign bit_fall_o = !s[0] && !hold_q && !s[1] && sck_p;
  assign mosi_o     = s[2];
endmodule

// File: rtl/spi_ee_engine.sv
module spi_ee_engine
  import spi_ee_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int PAGE  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(PAGE)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              cs_rise_i,
  input  logic              hold_i,
  input  logic              bit_rise_i,
  input  logic              bit_fall_i,
  input  logic              mosi_i,
  input  logic              busy_i,
  input  logic [7:0]        status_i,
  input  logic [7:0]        mem_rdata_i,
  output logic [AW-1:0]     mem_raddr_o,
  output logic              wren_o,
  output logic              wrdi_o,
  output logic              wrsr_o,
  output logic [1:0]        wrsr_bp_o,
  output logic              commit_o,
  output logic [AW-1:0]     commit_base_o,
  output logic [PAGE*8-1:0] commit_data_o,
  output logic [PAGE-1:0]   commit_mask_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  ee_state_e state_q;
  logic [2:0] cnt_q;
  logic [6:0] sh_q;
  logic [AW-1:0] addr_q, addr_next;
  logic a_hi_q, is_rd_q, got_q, oe_q, miso_q;
  logic [7:0] out_q;
  logic [1:0] bp_q;
  logic [PAGE-1:0][7:0] pbuf_q;
  logic [PAGE-1:0] pmask_q;
  logic wren_q, wrdi_q, wrsr_q, commit_q;

  logic [7:0] byte_w;
  logic [8:0] addr_full;
  logic byte_done;

  assign byte_w    = {sh_q, mosi_i};
  assign addr_full = {a_hi_q, byte_w};
  assign byte_done = bit_rise_i && (cnt_q == 3'd7);

  always_comb begin
    if (state_q == ST_ADDR) addr_next = addr_full[AW-1:0];
    else                    addr_next = addr_q + AW'(1);
  end
  assign mem_raddr_o = addr_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_OP;
      cnt_q    <= '0;
      sh_q     <= '0;
      addr_q   <= '0;
      a_hi_q   <= 1'b0;
      is_rd_q  <= 1'b0;
      got_q    <= 1'b0;
      oe_q     <= 1'b0;
      miso_q   <= 1'b0;
      out_q    <= '0;
      bp_q     <= '0;
      pbuf_q   <= '0;
      pmask_q  <= '0;
      wren_q   <= 1'b0;
      wrdi_q   <= 1'b0;
      wrsr_q   <= 1'b0;
      commit_q <= 1'b0;
    end else begin
      wren_q   <= 1'b0;
      wrdi_q   <= 1'b0;
      wrsr_q   <= 1'b0;
      commit_q <= 1'b0;
      if (!sel_i) begin
        // deselected: clear framing so the next selection starts on an opcode
        if (cs_rise_i && !hold_i && cnt_q == 3'd0) begin
          commit_q <= (state_q == ST_WR) && got_q;
          wrsr_q   <= (state_q == ST_SRD);
        end
        state_q <= ST_OP;
        cnt_q   <= '0;
        sh_q    <= '0;
        oe_q    <= 1'b0;
        got_q   <= 1'b0;
      end else begin
        if (bit_fall_i && (state_q == ST_RD || state_q == ST_SRO)) begin
          miso_q <= out_q[7];
          out_q  <= {out_q[6:0], 1'b0};
          oe_q   <= 1'b1;
        end
        if (bit_rise_i) begin
          sh_q  <= byte_w[6:0];
          cnt_q <= cnt_q + 3'd1;
        end
        if (byte_done) begin
          unique case (state_q)
            ST_OP: begin
              state_q <= ST_IGN;
              if (byte_w[7:4] == 4'd0) begin
                unique case (byte_w[2:0])
                  OPL_WREN: wren_q <= 1'b1;
                  OPL_WRDI: wrdi_q <= 1'b1;
                  OPL_RDSR: begin state_q <= ST_SRO; out_q <= status_i; end
                  OPL_WRSR: state_q <= ST_SRI;
                  OPL_READ, OPL_WRIT: if (!busy_i) begin
                    state_q <= ST_ADDR;
                    a_hi_q  <= byte_w[3];
                    is_rd_q <= byte_w[0];
                  end
                  default: ;
                endcase
              end
            end
            ST_ADDR: begin
              addr_q <= addr_next;
              if (is_rd_q) begin
                state_q <= ST_RD;
                out_q   <= mem_rdata_i;
              end else begin
                state_q <= ST_WR;
                pmask_q <= '0;
              end
            end
            ST_RD: begin
              addr_q <= addr_next;
              out_q  <= mem_rdata_i;
            end
            ST_SRO: out_q <= status_i;
            ST_SRI: begin
              bp_q    <= byte_w[3:2];
              state_q <= ST_SRD;
            end
            ST_SRD: state_q <= ST_IGN;
            ST_WR: begin
              pbuf_q[addr_q[PW-1:0]]  <= byte_w;
              pmask_q[addr_q[PW-1:0]] <= 1'b1;
              got_q                   <= 1'b1;
              addr_q <= {addr_q[AW-1:PW], addr_q[PW-1:0] + PW'(1)};
            end
            default: ;
          endcase
        end
      end
    end
  end

  assign wren_o        = wren_q;
  assign wrdi_o        = wrdi_q;
  assign wrsr_o        = wrsr_q;
  assign wrsr_bp_o     = bp_q;
  assign commit_o      = commit_q;
  assign commit_base_o = {addr_q[AW-1:PW], {PW{1'b0}}};
  assign commit_data_o = pbuf_q;
  assign commit_mask_o = pmask_q;
  assign miso_o        = miso_q;
  assign miso_oe_o     = oe_q && sel_i && !hold_i;

  AST_RD_NOT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |-> !busy_i);  // R8
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && sel_i) |=> $stable(cnt_q));  // R12
endmodule

// File: rtl/spi_ee_store.sv
module spi_ee_store #(
  parameter int DEPTH     = 512,
  parameter int PAGE      = 16,
  parameter int WR_CYCLES = 1000,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(WR_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [1:0]        wrsr_bp_i,
  input  logic              commit_i,
  input  logic [AW-1:0]     commit_base_i,
  input  logic [PAGE*8-1:0] commit_data_i,
  input  logic [PAGE-1:0]   commit_mask_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [7:0]        rdata_o,
  output logic [7:0]        status_o,
  output logic              busy_o
);
  logic [7:0] mem_q [DEPTH];
  logic wel_q, busy_q, sr_pend_q;
  logic [1:0] bp_q, bp_pend_q;
  logic [CW-1:0] tmr_q;
  logic [AW:0] lim;
  logic prot, acc_wr, acc_sr;

  always_comb begin
    unique case (bp_q)
      2'b01:   lim = (AW+1)'(DEPTH - DEPTH/4);
      2'b10:   lim = (AW+1)'(DEPTH/2);
      2'b11:   lim = '0;
      default: lim = (AW+1)'(DEPTH);
    endcase
  end

  assign prot   = {1'b0, commit_base_i} >= lim;
  assign acc_wr = commit_i && wel_q && !busy_q && !prot;
  assign acc_sr = wrsr_i && wel_q && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'hFF;
    end else if (acc_wr) begin
      for (int i = 0; i < PAGE; i++)
        if (commit_mask_i[i]) mem_q[commit_base_i + AW'(i)] <= commit_data_i[i*8 +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q     <= 1'b0;
      busy_q    <= 1'b0;
      sr_pend_q <= 1'b0;
      bp_q      <= '0;
      bp_pend_q <= '0;
      tmr_q     <= '0;
    end else begin
      if (acc_wr || acc_sr) begin
        busy_q    <= 1'b1;
        tmr_q     <= CW'(WR_CYCLES - 1);
        sr_pend_q <= acc_sr;
        bp_pend_q <= wrsr_bp_i;
      end else if (busy_q) begin
        if (tmr_q == '0) begin
          busy_q <= 1'b0;
          wel_q  <= 1'b0;
          if (sr_pend_q) bp_q <= bp_pend_q;
          sr_pend_q <= 1'b0;
        end else begin
          tmr_q <= tmr_q - CW'(1);
        end
      end
      if (wren_i) wel_q <= 1'b1;
      if (wrdi_i) wel_q <= 1'b0;
    end
  end

  assign rdata_o  = mem_q[raddr_i];
  assign status_o = {4'b0000, bp_q, wel_q, busy_q};
  assign busy_o   = busy_q;

  AST_BUSY_NEEDS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(commit_i || wrsr_i));  // R9
  AST_BUSY_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(wel_q));  // R7
  AST_WEL_FALL_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wel_q) |-> ($past(wrdi_i) || $fell(busy_q)));  // R9
endmodule

// File: rtl/spi_eeprom_slave.sv
module spi_eeprom_slave #(
  parameter int DEPTH     = 512,
  parameter int PAGE      = 16,
  parameter int WR_CYCLES = 1000,
  parameter int SYNC      = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic mosi_i,
  input  logic hold_ni,
  output logic miso_o,
  output logic miso_oe_o
);
  localparam int AW = $clog2(DEPTH);

  logic sel, cs_rise, hold, bit_rise, bit_fall, mosi_s, busy;
  logic wren, wrdi, wrsr, commit;
  logic [1:0] wrsr_bp;
  logic [7:0] status, rdata;
  logic [AW-1:0] raddr, cbase;
  logic [PAGE*8-1:0] cdata;
  logic [PAGE-1:0] cmask;

  spi_ee_frontend #(.SYNC(SYNC)) u_fe (
    .clk_i, .rst_ni, .cs_ni, .sck_i, .mosi_i, .hold_ni,
    .sel_o(sel), .cs_rise_o(cs_rise), .hold_o(hold),
    .bit_rise_o(bit_rise), .bit_fall_o(bit_fall), .mosi_o(mosi_s)
  );

  spi_ee_engine #(.DEPTH(DEPTH), .PAGE(PAGE)) u_eng (
    .clk_i, .rst_ni, .sel_i(sel), .cs_rise_i(cs_rise), .hold_i(hold),
    .bit_rise_i(bit_rise), .bit_fall_i(bit_fall), .mosi_i(mosi_s),
    .busy_i(busy), .status_i(status), .mem_rdata_i(rdata),
    .mem_raddr_o(raddr), .wren_o(wren), .wrdi_o(wrdi), .wrsr_o(wrsr),
    .wrsr_bp_o(wrsr_bp), .commit_o(commit), .commit_base_o(cbase),
    .commit_data_o(cdata), .commit_mask_o(cmask),
    .miso_o, .miso_oe_o
  );

  spi_ee_store #(.DEPTH(DEPTH), .PAGE(PAGE), .WR_CYCLES(WR_CYCLES)) u_st (
    .clk_i, .rst_ni, .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr),
    .wrsr_bp_i(wrsr_bp), .commit_i(commit), .commit_base_i(cbase),
    .commit_data_i(cdata), .commit_mask_i(cmask), .raddr_i(raddr),
    .rdata_o(rdata), .status_o(status), .busy_o(busy)
  );
endmodule

// File: tb/tb_spi_eeprom_slave.sv
module tb_spi_eeprom_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int WR = 2000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, mosi = 1'b0, hold_n = 1'b1;
  logic miso, miso_oe;
  logic oe_seen;
  int checks = 0, fails = 0;

  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] rx_byte;
  event rx_ev;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_eeprom_slave #(.WR_CYCLES(WR)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .mosi_i(mosi),
    .hold_ni(hold_n), .miso_o(miso), .miso_oe_o(miso_oe)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", tag, act, expv);
    end
  endtask

  // monitor: pops expected items as read bytes arrive
  initial forever begin
    @(rx_ev);
    if (exp_q.size() == 0) chk("scoreboard-empty", 8'h00, 8'h01);
    else chk(tag_q.pop_front(), rx_byte, exp_q.pop_front());
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    @(negedge clk) mosi = b;
    wait_clk(HALF);
    r = miso;
    if (miso_oe) oe_seen = 1'b1;
    sck = 1'b1;
    wait_clk(HALF);
    sck = 1'b0;
  endtask

  task automatic xfer_n(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      logic r;
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic xfer(input logic [7:0] tx);
    logic [7:0] d;
    xfer_n(tx, 8, d);
  endtask

  task automatic rd_expect(input string tag, input logic [7:0] expv);
    logic [7:0] d;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
    xfer_n(8'h00, 8, d);
    rx_byte = d;
    -> rx_ev;
    #1;
  endtask

  task automatic cs_lo;
    @(negedge clk) cs_n = 1'b0;
    oe_seen = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_hi;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF + 4);
  endtask

  task automatic cmd1(input logic [7:0] op);
    cs_lo; xfer(op); cs_hi;
  endtask

  task automatic rdsr(input string tag, input logic [7:0] expv);
    cs_lo; xfer(8'h05); rd_expect(tag, expv); cs_hi;
  endtask

  task automatic wr_seq(input logic [8:0] a, input int n, input logic [7:0] first);
    cs_lo;
    xfer({4'b0000, a[8], 3'b010});
    xfer(a[7:0]);
    for (int i = 0; i < n; i++) xfer(first + 8'(i));
    cs_hi;
  endtask

  task automatic rd_start(input logic [8:0] a);
    cs_lo;
    xfer({4'b0000, a[8], 3'b011});
    xfer(a[7:0]);
  endtask

  task automatic rd1(input string tag, input logic [8:0] a, input logic [7:0] expv);
    rd_start(a); rd_expect(tag, expv); cs_hi;
  endtask

  task automatic wait_wr;
    wait_clk(WR + 50);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk("R1 oe idle", 8'(miso_oe), 8'h00);
    rdsr("R1 status", 8'h00);
    rd1("R1 mem", 9'h1A5, 8'hFF);

    // R2 latch set/clear and status layout
    cmd1(8'h06);
    rdsr("R2 wren", 8'h02);
    cmd1(8'h04);
    rdsr("R2 wrdi", 8'h00);

    // R7 write without latch
    wr_seq(9'h010, 1, 8'h55);
    rdsr("R7 no busy", 8'h00);
    rd1("R7 mem", 9'h010, 8'hFF);

    // R3 write at A8 set, R8 busy behaviour, R9 completion
    cmd1(8'h06);
    wr_seq(9'h1A5, 1, 8'h3C);
    rdsr("R9 busy", 8'h03);
    rd_start(9'h1A5);
    begin
      logic [7:0] d;
      xfer_n(8'h00, 8, d);
    end
    chk("R8 read rejected", 8'(oe_seen), 8'h00);
    cs_hi;
    wait_wr;
    rdsr("R9 done", 8'h00);
    rd1("R3 hi", 9'h1A5, 8'h3C);
    rd1("R3 lo", 9'h0A5, 8'hFF);

    // R4 page wrap: start at offset 3, 17 bytes
    cmd1(8'h06);
    wr_seq(9'h023, 17, 8'h40);
    wait_wr;
    rd_start(9'h020);
    for (int o = 0; o < 16; o++) begin
      logic [7:0] e;
      if (o < 3) e = 8'h4D + 8'(o);
      else if (o == 3) e = 8'h50;
      else e = 8'h40 + 8'(o - 3);
      rd_expect("R4 page", e);
    end
    cs_hi;
    rd1("R4 next page", 9'h030, 8'hFF);

    // R5 array wrap on read
    cmd1(8'h06); wr_seq(9'h1FE, 2, 8'hA1); wait_wr;
    cmd1(8'h06); wr_seq(9'h000, 2, 8'hB1); wait_wr;
    rd_start(9'h1FE);
    rd_expect("R5 1FE", 8'hA1);
    rd_expect("R5 1FF", 8'hA2);
    rd_expect("R5 000", 8'hB1);
    rd_expect("R5 001", 8'hB2);
    cs_hi;

    // R6 CS rising mid-byte discards the write
    cmd1(8'h06);
    cs_lo;
    xfer(8'h02); xfer(8'h60); xfer(8'h77);
    begin
      logic [7:0] d;
      xfer_n(8'hF0, 4, d);
    end
    cs_hi;
    rdsr("R6 no commit", 8'h02);
    rd1("R6 fresh", 9'h060, 8'hFF);
    cmd1(8'h04);

    // R10 protection
    cmd1(8'h06);
    cs_lo; xfer(8'h01); xfer(8'h04); cs_hi;
    rdsr("R10 frozen", 8'h03);
    wait_wr;
    rdsr("R10 applied", 8'h04);
    cmd1(8'h06);
    wr_seq(9'h190, 1, 8'h11);
    rdsr("R10 rejected", 8'h06);
    rd1("R10 prot mem", 9'h190, 8'hFF);
    wr_seq(9'h170, 1, 8'h22);
    wait_wr;
    rd1("R10 open mem", 9'h170, 8'h22);
    cmd1(8'h06);
    cs_lo; xfer(8'h01); xfer(8'h00); cs_hi;
    wait_wr;
    rdsr("R10 cleared", 8'h00);

    // R11 invalid opcodes
    cs_lo; xfer(8'h87); xfer(8'h06); cs_hi;
    rdsr("R11 ignored", 8'h00);
    cs_lo; xfer(8'h13); xfer(8'h20);
    begin
      logic [7:0] d;
      xfer_n(8'h00, 8, d);
    end
    chk("R11 no drive", 8'(oe_seen), 8'h00);
    cs_hi;

    // R12 hold during a read
    rd_start(9'h020);
    rd_expect("R12 before", 8'h4D);
    @(negedge clk) hold_n = 1'b0;
    wait_clk(HALF);
    chk("R12 oe off", 8'(miso_oe), 8'h00);
    for (int k = 0; k < 3; k++) begin
      logic r;
      bit_x(1'b1, r);
    end
    wait_clk(HALF);
    hold_n = 1'b1;
    wait_clk(HALF);
    rd_expect("R12 after", 8'h4E);
    cs_hi;

    // R13 deselect during hold abandons a write
    cmd1(8'h06);
    cs_lo; xfer(8'h02); xfer(8'h80); xfer(8'h99);
    @(negedge clk) hold_n = 1'b0;
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2*HALF);
    hold_n = 1'b1;
    wait_clk(2*HALF);
    rdsr("R13 no commit", 8'h02);
    rd1("R13 mem", 9'h080, 8'hFF);

    wait_clk(10);
    chk("scoreboard drained", 8'(exp_q.size()), 8'h00);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule